// File: doc/BRIEF.md
# Tagged Prefetch-Victim Side Buffer

This block is a small set-associative tag store that sits next to a second-level cache. It receives two kinds of lines: lines brought in early by a prefetcher and lines pushed out of the second-level cache. Each stored entry keeps a single origin flag that records which of the two kinds it is. The flag travels with the line and is reported when the line leaves, whether it leaves by a probe hit or by replacement.

On a second-level miss the surrounding logic probes the buffer. A hit removes the line from the buffer and reports its origin, so the requester can move the line into the second-level cache and the two structures never hold the same line. An insert that finds its set full pushes out the least recently inserted way and reports that line's address and origin for one cycle. Any line that leaves by replacement was never claimed by a probe. Four saturating counters track accepted inserts and unused evictions for each origin. The ratio of unused prefetch evictions to prefetch inserts is the fraction of prefetches that failed. Line data is not stored; only tags are kept.

Top module: `side_buffer`

## Requirements
- R1: Each line address maps to set `addr[SET_W-1:0]`; one set holds up to WAYS (default 4) distinct line addresses at once, and lines in different sets do not disturb each other.
- R2: A probe (`prb_valid`) whose address is present raises `prb_hit` for one cycle on the next clock edge, with `prb_hit_pf` giving the stored origin (1 = prefetch, 0 = victim). The line is removed, so a later probe of the same address misses.
- R3: A probe whose address is absent leaves `prb_hit` low and changes no stored line.
- R4: Inserting an absent address into a set that has a free way fills that way and raises no eviction.
- R5: Inserting an absent address into a full set replaces the least recently used way. On the next edge `evict_valid` is high for one cycle, with that way's full line address on `evict_addr` and its origin on `evict_pf`.
- R6: Every accepted insert, for either origin, makes its line the most recently used in its set. A probe hit does not promote any line.
- R7: Inserting an address that is already present creates no second copy and no eviction. It replaces the stored origin with `ins_pf` and makes the line most recently used.
- R8: When a probe and an insert are requested in the same cycle, the probe is served and the insert is dropped: nothing is stored and nothing is counted.
- R9: `pf_ins_cnt` counts accepted inserts with `ins_pf`=1, and `vic_ins_cnt` counts those with `ins_pf`=0. Re-inserts are included. The counters change on the edge that accepts the insert.
- R10: `pf_fail_cnt` and `vic_fail_cnt` count replacement evictions of prefetch-origin and victim-origin lines. Each updates on the same edge that raises `evict_valid`.
- R11: Every counter stops at 2^CNT_W-1 and does not wrap.
- R12: `cnt_clr` zeroes all four counters on the next edge and takes priority over any increment in that cycle. It does not affect the stored lines.
- R13: After reset every way is empty, `prb_hit` and `evict_valid` are low, and all counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Insert request |
| ins_addr | input | ADDR_W | Line address to insert |
| ins_pf | input | 1 | Origin of inserted line: 1 prefetch, 0 victim |
| prb_valid | input | 1 | Probe request (served before an insert) |
| prb_addr | input | ADDR_W | Line address to probe |
| prb_hit | output | 1 | Probe found and removed the line |
| prb_hit_pf | output | 1 | Origin of the line removed by the probe |
| evict_valid | output | 1 | A line was replaced by an insert |
| evict_addr | output | ADDR_W | Line address of the replaced line |
| evict_pf | output | 1 | Origin of the replaced line |
| cnt_clr | input | 1 | Synchronous clear of all counters |
| pf_ins_cnt | output | CNT_W | Prefetch-origin inserts |
| pf_fail_cnt | output | CNT_W | Prefetch-origin lines replaced unused |
| vic_ins_cnt | output | CNT_W | Victim-origin inserts |
| vic_fail_cnt | output | CNT_W | Victim-origin lines replaced unused |

## Verification
The hardest situation to produce from the ports is a full set whose recency order has been disturbed, both by a re-insert that moves an old line to the front and by a probe that leaves a hole. This state is the only place where a wrong age update shows up as the wrong victim. The stimulus sends five aliasing addresses into a single set index. It mixes origins and re-inserts one line with a new origin. Each later eviction address is then compared with the order expected from R6 and R7. A probe and an insert in the same cycle, followed by a probe for the dropped address, exposes whether the collision leaked into the store.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {
    SB_IDLE   = 2'd0,
    SB_PROBE  = 2'd1,
    SB_INSERT = 2'd2
  } sb_op_e;

  localparam int unsigned SB_NUM_CNT   = 4;
  localparam int unsigned CNT_PF_INS   = 0;
  localparam int unsigned CNT_VIC_INS  = 1;
  localparam int unsigned CNT_PF_FAIL  = 2;
  localparam int unsigned CNT_VIC_FAIL = 3;
endpackage

// File: rtl/sb_rst_sync.sv
module sb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_ns = sync_q[1];
endmodule

// File: rtl/sb_lookup.sv
module sb_lookup #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 28,
  parameter int WAY_W = 2
) (
  input  logic [WAYS-1:0]       vld,
  input  logic [WAYS*TAG_W-1:0] tags,
  input  logic [WAYS*WAY_W-1:0] ages,
  input  logic [TAG_W-1:0]      key,
  output logic                  hit,
  output logic [WAY_W-1:0]      hit_way,
  output logic                  free,
  output logic [WAY_W-1:0]      free_way,
  output logic [WAY_W-1:0]      lru_way
);
  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = vld[w] && (tags[w*TAG_W +: TAG_W] == key);
  end

  assign hit  = |match;
  assign free = ~&vld;

  always_comb begin
    hit_way  = '0;
    free_way = '0;
    lru_way  = '0;
    for (int w = WAYS-1; w >= 0; w--) begin
      if (match[w])                                    hit_way  = WAY_W'(w);
      if (!vld[w])                                     free_way = WAY_W'(w);
      if (ages[w*WAY_W +: WAY_W] == WAY_W'(WAYS-1))     lru_way  = WAY_W'(w);
    end
  end
endmodule

// File: rtl/sb_age_upd.sv
module sb_age_upd #(
  parameter int WAYS  = 4,
  parameter int WAY_W = 2
) (
  input  logic [WAYS*WAY_W-1:0] ages,
  input  logic                  en,
  input  logic                  rm,
  input  logic [WAY_W-1:0]      way,
  output logic [WAYS*WAY_W-1:0] ages_d
);
  localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS-1);

  logic [WAY_W-1:0] ref_age;
  assign ref_age = ages[way*WAY_W +: WAY_W];

  for (genvar i = 0; i < WAYS; i++) begin : g_way
    logic [WAY_W-1:0] cur;
    logic             self;
    assign cur  = ages[i*WAY_W +: WAY_W];
    assign self = (WAY_W'(i) == way);
    assign ages_d[i*WAY_W +: WAY_W] =
      !en  ? cur :
      rm   ? (self ? OLDEST : ((cur > ref_age) ? cur - 1'b1 : cur)) :
             (self ? '0     : ((cur < ref_age) ? cur + 1'b1 : cur));
  end
endmodule

// File: rtl/sb_sat_cnt.sv
module sb_sat_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] q
);
  logic [CNT_W-1:0] q_d;
  logic             q_en;

  always_comb begin
    q_en = clr || (inc && !(&q));
    q_d  = clr ? '0 : q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_d;
  end
endmodule

// File: rtl/side_buffer.sv
module side_buffer #(
  parameter int ADDR_W = 32,
  parameter int SET_W  = 4,
  parameter int WAYS   = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic              ins_pf,
  input  logic              prb_valid,
  input  logic [ADDR_W-1:0] prb_addr,
  output logic              prb_hit,
  output logic              prb_hit_pf,
  output logic              evict_valid,
  output logic [ADDR_W-1:0] evict_addr,
  output logic              evict_pf,
  input  logic              cnt_clr,
  output logic [CNT_W-1:0]  pf_ins_cnt,
  output logic [CNT_W-1:0]  pf_fail_cnt,
  output logic [CNT_W-1:0]  vic_ins_cnt,
  output logic [CNT_W-1:0]  vic_fail_cnt
);
  import sb_pkg::*;

  localparam int SETS  = 1 << SET_W;
  localparam int TAG_W = ADDR_W - SET_W;
  localparam int WAY_W = $clog2(WAYS);

  logic rst_ns;
  sb_rst_sync i_rst (.clk(clk), .rst_n(rst_n), .rst_ns(rst_ns));

  // Tag store, one row per set
  logic [WAYS-1:0]       vld_q [SETS];
  logic [WAYS-1:0]       pf_q  [SETS];
  logic [WAYS*TAG_W-1:0] tag_q [SETS];
  logic [WAYS*WAY_W-1:0] age_q [SETS];

  sb_op_e            op;
  logic [ADDR_W-1:0] op_addr;
  logic [SET_W-1:0]  set_idx;
  logic [TAG_W-1:0]  key;

  always_comb begin
    if (prb_valid)      op = SB_PROBE;
    else if (ins_valid) op = SB_INSERT;
    else                op = SB_IDLE;
    op_addr = (op == SB_PROBE) ? prb_addr : ins_addr;
    set_idx = op_addr[SET_W-1:0];
    key     = op_addr[ADDR_W-1:SET_W];
  end

  logic [WAYS-1:0]       row_vld, row_pf;
  logic [WAYS*TAG_W-1:0] row_tag;
  logic [WAYS*WAY_W-1:0] row_age;

  assign row_vld = vld_q[set_idx];
  assign row_pf  = pf_q[set_idx];
  assign row_tag = tag_q[set_idx];
  assign row_age = age_q[set_idx];

  logic             hit, free;
  logic [WAY_W-1:0] hit_way, free_way, lru_way;

  sb_lookup #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) i_lookup (
    .vld(row_vld), .tags(row_tag), .ages(row_age), .key(key),
    .hit(hit), .hit_way(hit_way), .free(free), .free_way(free_way),
    .lru_way(lru_way)
  );

  // Next-state for the addressed row and the result outputs
  logic [WAYS-1:0]       vld_d, pf_d;
  logic [WAYS*TAG_W-1:0] tag_d;
  logic                  row_we;
  logic                  age_en, age_rm;
  logic [WAY_W-1:0]      age_way, tgt_way;
  logic                  hit_d, hit_pf_d, ev_d, ev_pf_d;
  logic [ADDR_W-1:0]     ev_addr_d;
  logic [SB_NUM_CNT-1:0] inc_d;

  always_comb begin
    vld_d     = row_vld;
    pf_d      = row_pf;
    tag_d     = row_tag;
    row_we    = 1'b0;
    age_en    = 1'b0;
    age_rm    = 1'b0;
    age_way   = '0;
    tgt_way   = '0;
    hit_d     = 1'b0;
    hit_pf_d  = 1'b0;
    ev_d      = 1'b0;
    ev_pf_d   = 1'b0;
    ev_addr_d = '0;
    inc_d     = '0;
    case (op)
      SB_PROBE: begin
        if (hit) begin
          vld_d[hit_way] = 1'b0;
          row_we   = 1'b1;
          age_en   = 1'b1;
          age_rm   = 1'b1;
          age_way  = hit_way;
          hit_d    = 1'b1;
          hit_pf_d = row_pf[hit_way];
        end
      end
      SB_INSERT: begin
        if (hit)       tgt_way = hit_way;
        else if (free) tgt_way = free_way;
        else begin
          tgt_way   = lru_way;
          ev_d      = 1'b1;
          ev_pf_d   = row_pf[lru_way];
          ev_addr_d = {row_tag[lru_way*TAG_W +: TAG_W], set_idx};
          if (row_pf[lru_way]) inc_d[CNT_PF_FAIL]  = 1'b1;
          else                 inc_d[CNT_VIC_FAIL] = 1'b1;
        end
        vld_d[tgt_way] = 1'b1;
        pf_d[tgt_way]  = ins_pf;
        tag_d[tgt_way*TAG_W +: TAG_W] = key;
        row_we  = 1'b1;
        age_en  = 1'b1;
        age_way = tgt_way;
        if (ins_pf) inc_d[CNT_PF_INS]  = 1'b1;
        else        inc_d[CNT_VIC_INS] = 1'b1;
      end
      default: ;
    endcase
  end

  logic [WAYS*WAY_W-1:0] age_d;

  sb_age_upd #(.WAYS(WAYS), .WAY_W(WAY_W)) i_age (
    .ages(row_age), .en(age_en), .rm(age_rm), .way(age_way), .ages_d(age_d)
  );

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        pf_q[s]  <= '0;
        tag_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) age_q[s][w*WAY_W +: WAY_W] <= WAY_W'(w);
      end
    end else if (row_we) begin
      vld_q[set_idx] <= vld_d;
      pf_q[set_idx]  <= pf_d;
      tag_q[set_idx] <= tag_d;
      age_q[set_idx] <= age_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      prb_hit     <= 1'b0;
      prb_hit_pf  <= 1'b0;
      evict_valid <= 1'b0;
      evict_pf    <= 1'b0;
      evict_addr  <= '0;
    end else begin
      prb_hit     <= hit_d;
      prb_hit_pf  <= hit_pf_d;
      evict_valid <= ev_d;
      evict_pf    <= ev_pf_d;
      evict_addr  <= ev_addr_d;
    end
  end

  // Usage counters
  logic [CNT_W-1:0] cnt_q [SB_NUM_CNT];

  for (genvar c = 0; c < SB_NUM_CNT; c++) begin : g_cnt
    sb_sat_cnt #(.CNT_W(CNT_W)) i_cnt (
      .clk(clk), .rst_n(rst_ns), .clr(cnt_clr), .inc(inc_d[c]), .q(cnt_q[c])
    );
  end

  assign pf_ins_cnt   = cnt_q[CNT_PF_INS];
  assign vic_ins_cnt  = cnt_q[CNT_VIC_INS];
  assign pf_fail_cnt  = cnt_q[CNT_PF_FAIL];
  assign vic_fail_cnt = cnt_q[CNT_VIC_FAIL];
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ins_valid,
  input logic              prb_valid,
  input logic [ADDR_W-1:0] prb_addr,
  input logic              prb_hit,
  input logic              evict_valid,
  input logic              evict_pf,
  input logic              cnt_clr,
  input logic [CNT_W-1:0]  pf_ins_cnt,
  input logic [CNT_W-1:0]  pf_fail_cnt,
  input logic [CNT_W-1:0]  vic_ins_cnt,
  input logic [CNT_W-1:0]  vic_fail_cnt
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  // R2
  hit_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prb_hit |-> $past(prb_valid));

  // R2
  removed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prb_hit && prb_valid && $past(prb_valid) && prb_addr == $past(prb_addr)) |=> !prb_hit);

  // R5
  evict_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evict_valid |-> $past(ins_valid && !prb_valid));

  // R8
  hit_evict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prb_hit |-> !evict_valid);

  // R9
  ins_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cnt_clr) |-> (pf_ins_cnt == $past(pf_ins_cnt) ||
                         pf_ins_cnt == $past(pf_ins_cnt) + CNT_W'(1)));

  // R10
  fail_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cnt_clr) && pf_fail_cnt != $past(pf_fail_cnt)) |-> (evict_valid && evict_pf));

  // R11
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_ins_cnt == CMAX && !cnt_clr) |=> pf_ins_cnt == CMAX);

  // R12
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cnt_clr) |-> (pf_ins_cnt == '0 && pf_fail_cnt == '0 &&
                        vic_ins_cnt == '0 && vic_fail_cnt == '0));
endmodule

bind side_buffer sb_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_sb_checker (
  .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .prb_valid(prb_valid),
  .prb_addr(prb_addr), .prb_hit(prb_hit), .evict_valid(evict_valid),
  .evict_pf(evict_pf), .cnt_clr(cnt_clr), .pf_ins_cnt(pf_ins_cnt),
  .pf_fail_cnt(pf_fail_cnt), .vic_ins_cnt(vic_ins_cnt), .vic_fail_cnt(vic_fail_cnt)
);

// File: tb/test_side_buffer.sv
module test_side_buffer;
  localparam int ADDR_W = 8;
  localparam int SET_W  = 2;
  localparam int WAYS   = 4;
  localparam int CNT_W  = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic ins_valid, ins_pf, prb_valid, cnt_clr;
  logic [ADDR_W-1:0] ins_addr, prb_addr;
  logic prb_hit, prb_hit_pf, evict_valid, evict_pf;
  logic [ADDR_W-1:0] evict_addr;
  logic [CNT_W-1:0] pf_ins_cnt, pf_fail_cnt, vic_ins_cnt, vic_fail_cnt;

  always #2 clk = ~clk;

  side_buffer #(.ADDR_W(ADDR_W), .SET_W(SET_W), .WAYS(WAYS), .CNT_W(CNT_W)) i_side_buffer (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_addr(ins_addr),
    .ins_pf(ins_pf), .prb_valid(prb_valid), .prb_addr(prb_addr),
    .prb_hit(prb_hit), .prb_hit_pf(prb_hit_pf), .evict_valid(evict_valid),
    .evict_addr(evict_addr), .evict_pf(evict_pf), .cnt_clr(cnt_clr),
    .pf_ins_cnt(pf_ins_cnt), .pf_fail_cnt(pf_fail_cnt),
    .vic_ins_cnt(vic_ins_cnt), .vic_fail_cnt(vic_fail_cnt)
  );

  typedef struct {
    logic        hit;
    logic        hpf;
    logic        ev;
    logic [7:0]  ea;
    logic        epf;
    string       req;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;

  // Monitor: compares each cycle's result against the queued expectation
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      checks++;
      if (prb_hit !== it.hit || (it.hit && prb_hit_pf !== it.hpf) ||
          evict_valid !== it.ev ||
          (it.ev && (evict_addr !== it.ea || evict_pf !== it.epf))) begin
        fails++;
        $display("FAIL %s: hit=%b/%b ev=%b addr=%h pf=%b, expected hit=%b/%b ev=%b addr=%h pf=%b",
                 it.req, prb_hit, prb_hit_pf, evict_valid, evict_addr, evict_pf,
                 it.hit, it.hpf, it.ev, it.ea, it.epf);
      end
    end
  end

  task automatic step(input logic iv, input logic [7:0] ia, input logic ipf,
                      input logic pv, input logic [7:0] pa, input logic clr,
                      input exp_t e);
    ins_valid = iv; ins_addr = ia; ins_pf = ipf;
    prb_valid = pv; prb_addr = pa; cnt_clr = clr;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic ins(input logic [7:0] a, input logic pf, input logic ev,
                     input logic [7:0] ea, input logic epf, input string req);
    exp_t e;
    e.hit = 0; e.hpf = 0; e.ev = ev; e.ea = ea; e.epf = epf; e.req = req;
    step(1'b1, a, pf, 1'b0, 8'h00, 1'b0, e);
  endtask

  task automatic prb(input logic [7:0] a, input logic hit, input logic hpf, input string req);
    exp_t e;
    e.hit = hit; e.hpf = hpf; e.ev = 0; e.ea = 0; e.epf = 0; e.req = req;
    step(1'b0, 8'h00, 1'b0, 1'b1, a, 1'b0, e);
  endtask

  task automatic idle();
    exp_t e;
    e.hit = 0; e.hpf = 0; e.ev = 0; e.ea = 0; e.epf = 0; e.req = "idle";
    step(1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, e);
  endtask

  task automatic chk_cnt(input int pi, input int pfl, input int vi, input int vfl,
                         input string req);
    checks++;
    if (pf_ins_cnt !== CNT_W'(pi) || pf_fail_cnt !== CNT_W'(pfl) ||
        vic_ins_cnt !== CNT_W'(vi) || vic_fail_cnt !== CNT_W'(vfl)) begin
      fails++;
      $display("FAIL %s: counters %0d %0d %0d %0d, expected %0d %0d %0d %0d", req,
               pf_ins_cnt, pf_fail_cnt, vic_ins_cnt, vic_fail_cnt, pi, pfl, vi, vfl);
    end
  endtask

  initial begin
    for (int n = 0; n < 20000; n++) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    exp_t e;
    rst_n = 1'b0;
    ins_valid = 0; ins_addr = 0; ins_pf = 0;
    prb_valid = 0; prb_addr = 0; cnt_clr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R13 reset state
    checks++;
    if (prb_hit !== 1'b0 || evict_valid !== 1'b0) begin
      fails++;
      $display("FAIL R13: hit=%b ev=%b, expected 0 0", prb_hit, evict_valid);
    end
    chk_cnt(0, 0, 0, 0, "R13 counters");
    prb(8'h01, 0, 0, "R13 empty probe");

    // R1 R4 fill set 1 with four aliasing lines
    ins(8'h01, 1, 0, 0, 0, "R4 fill");
    ins(8'h05, 0, 0, 0, 0, "R4 fill");
    ins(8'h09, 1, 0, 0, 0, "R4 fill");
    ins(8'h0D, 0, 0, 0, 0, "R1 fourth way");
    // R5 full set replaces oldest
    ins(8'h11, 1, 1, 8'h01, 1, "R5 evict oldest");
    chk_cnt(3, 1, 2, 0, "R10 after first eviction");
    // R7 re-insert with new origin, no eviction
    ins(8'h05, 1, 0, 0, 0, "R7 reinsert");
    // R6 re-insert made 05 newest, so 09 goes next
    ins(8'h15, 0, 1, 8'h09, 1, "R6 order after reinsert");
    // R2 R7 probe reports updated origin and removes
    prb(8'h05, 1, 1, "R2 R7 hit origin");
    prb(8'h05, 0, 0, "R2 removed");
    // R3 absent line
    prb(8'h01, 0, 0, "R3 miss");
    // R4 freed way reused without eviction
    ins(8'h19, 0, 0, 0, 0, "R4 hole reuse");
    ins(8'h1D, 1, 1, 8'h0D, 0, "R5 victim origin evict");
    // R8 probe and insert together
    e.hit = 1; e.hpf = 1; e.ev = 0; e.ea = 0; e.epf = 0; e.req = "R8 collide";
    step(1'b1, 8'h21, 1'b0, 1'b1, 8'h11, 1'b0, e);
    prb(8'h21, 0, 0, "R8 insert dropped");
    // R1 other set independent
    ins(8'h02, 1, 0, 0, 0, "R1 other set");
    prb(8'h02, 1, 1, "R1 other set hit");
    prb(8'h15, 1, 0, "R1 set 1 intact");
    idle();
    chk_cnt(6, 2, 4, 1, "R9 R10 totals");

    // R12 clear wins over a same-cycle increment
    e.hit = 0; e.hpf = 0; e.ev = 0; e.ea = 0; e.epf = 0; e.req = "R12 clear";
    step(1'b1, 8'h03, 1'b1, 1'b0, 8'h00, 1'b1, e);
    chk_cnt(0, 0, 0, 0, "R12 cleared");
    prb(8'h03, 1, 1, "R12 store unaffected");

    // R11 saturation
    for (int k = 0; k < 20; k++) ins(8'h04, 1, 0, 0, 0, "R11 repeat insert");
    idle();
    chk_cnt(15, 0, 0, 0, "R11 saturated");
    idle();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule